// File: doc/BRIEF.md
# Programmable Binary Timer

This block is a synchronous binary timer with sixteen stages. A one-cycle clock-enable pulse, `tick`, takes the place of a free-running oscillator. Each tick that arrives while no reset is active advances the count by one. A two-bit tap select picks one of four counter stages, and that stage sets the division ratio. The block then uses the tapped stage in one of two ways:

- **Recycle mode.** The tapped stage drives a free-running square wave on the output.
- **Single-cycle mode.** The output changes once, when half of the selected period has elapsed, and then stays at that level.

The block has two reset sources, which share the same clearing action:

- A master reset input.
- A power-on reset request. This request takes effect only while the auto-reset-disable input is low.

While either reset is active, the output sits at a level chosen by a polarity input. A change of the mode input also restarts the timer and re-arms single-cycle operation, with no reset needed.

Top module: `binary_timer`

## Requirements
- R1: The tap select `{sel_a, sel_b}` picks the stage whose bit drives the output. The codes map as follows: 2'b00 to stage 13, 2'b01 to stage 10, 2'b10 to stage 8 and 2'b11 to stage 16. Stage n is counter bit n-1, so after reset the output first changes after 4096, 512, 128 or 32768 ticks respectively.
- R2: The count advances by exactly one on each rising clock edge that samples `tick` high with no reset and no mode change. With `tick` low the count, and therefore the output, holds.
- R3: While `mstr_rst` is 1, every stage is cleared and the count stays at zero whatever `tick` does. The output shows the reset level one clock after reset is sampled.
- R4: `pwr_rst_req` clears the timer exactly as master reset does when `auto_rst_off` is 0. When `auto_rst_off` is 1, `pwr_rst_req` has no effect on the count or the output.
- R5: The reset level of `tmr_out` equals `pol_hi`: 0 gives a low output and 1 gives a high output.
- R6: With `recycle` at 1, the output starts at the reset level and flips every 2^(n-1) ticks. The result is a square wave of period 2^n ticks.
- R7: With `recycle` at 0, the output flips to the opposite of the reset level after 2^(n-1) ticks. It then holds that level under any further ticks, including a wrap of the counter.
- R8: Any change of `recycle` clears the count and the single-cycle latch. The output returns to the reset level and timing starts again from zero.
- R9: A change of the tap select during counting takes effect on the next clock edge, without clearing the count.
- R10: The output is registered. It changes one clock after the edge at which the tick that completes the count is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| tick | input | 1 | Count-enable pulse standing in for the oscillator |
| mstr_rst | input | 1 | Master reset, active high, synchronous |
| pwr_rst_req | input | 1 | Power-on reset request, active high |
| auto_rst_off | input | 1 | 1 masks `pwr_rst_req` |
| sel_a | input | 1 | Upper bit of the tap select |
| sel_b | input | 1 | Lower bit of the tap select |
| recycle | input | 1 | 1 = free-running divider, 0 = single-cycle timer |
| pol_hi | input | 1 | Output level during reset |
| tmr_out | output | 1 | Registered timer output |

## Verification
The hardest state to reach from the ports is the single-cycle latch after the counter has wrapped past the tapped stage. The tapped bit has returned to zero by then, so only the latch keeps the output inverted. To get there, the stimulus drives the shortest tap for well over a full period after the flip and confirms that the level holds. It then toggles `recycle` to show that re-arming goes through the mode-change path and not through a reset. The long tap at stage 16 is exercised only once, with a continuous tick burst, to keep the run short.

// File: rtl/bt_pkg.sv
package bt_pkg;

  // Tap select codes, built as {sel_a, sel_b}
  typedef enum logic [1:0] {
    TAP_MID  = 2'b00,
    TAP_LOW  = 2'b01,
    TAP_SHORT = 2'b10,
    TAP_FULL = 2'b11
  } tap_sel_e;

  function automatic tap_sel_e pack_sel(input logic a, input logic b);
    return tap_sel_e'({a, b});
  endfunction

  // Stage n of the counter is held in bit n-1
  function automatic int unsigned stage_bit(input int unsigned stage);
    return stage - 1;
  endfunction

  // Stage number associated with a select code, given the four taps
  function automatic int unsigned stage_for_code(
    input int unsigned code,
    input int unsigned s00,
    input int unsigned s01,
    input int unsigned s10,
    input int unsigned s11
  );
    case (code)
      0:       return s00;
      1:       return s01;
      2:       return s10;
      default: return s11;
    endcase
  endfunction

  // Ticks from reset to the first output change for a given stage
  function automatic longint unsigned half_period(input int unsigned stage);
    return longint'(1) << (stage - 1);
  endfunction

endpackage

// File: rtl/bt_stage_counter.sv
module bt_stage_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         adv,
  output logic [W-1:0] cnt
);

  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q;

  // Clear has priority over advance: the oscillator stand-in is frozen in reset
  always_ff @(posedge clk) begin
    if (clr)
      cnt_q <= '0;
    else if (adv)
      cnt_q <= cnt_q + ONE;
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/bt_tap_mux.sv
module bt_tap_mux
  import bt_pkg::*;
#(
  parameter int unsigned W   = 16,
  parameter int unsigned S00 = 13,
  parameter int unsigned S01 = 10,
  parameter int unsigned S10 = 8,
  parameter int unsigned S11 = 16
) (
  input  logic [W-1:0] cnt,
  input  tap_sel_e     sel,
  output logic         tap
);

  localparam int unsigned NTAP = 4;

  logic [NTAP-1:0] taps;

  // One tap wire per select code, each wired to its own counter bit
  for (genvar g = 0; g < NTAP; g++) begin : g_tap
    localparam int unsigned STG = stage_for_code(g, S00, S01, S10, S11);
    localparam int unsigned BIT = stage_bit(STG);
    assign taps[g] = cnt[BIT];
  end

  assign tap = taps[sel];

endmodule

// File: rtl/bt_shot_ctl.sv
module bt_shot_ctl (
  input  logic clk,
  input  logic rst_act,
  input  logic recycle,
  input  logic tap,
  output logic mode_chg,
  output logic shot
);

  logic mode_q;
  logic shot_q;
  logic shot_set;

  // Registered copy of the mode input; any difference is a restart event
  always_ff @(posedge clk) begin
    mode_q <= recycle;
  end

  assign mode_chg = recycle ^ mode_q;

  // Latch sets once the tapped stage first goes high in single-cycle mode
  assign shot_set = !recycle && tap;

  always_ff @(posedge clk) begin
    if (rst_act || mode_chg)
      shot_q <= 1'b0;
    else if (shot_set)
      shot_q <= 1'b1;
  end

  assign shot = shot_q;

endmodule

// File: rtl/binary_timer.sv
module binary_timer
  import bt_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned STG_00 = 13,
  parameter int unsigned STG_01 = 10,
  parameter int unsigned STG_10 = 8,
  parameter int unsigned STG_11 = 16
) (
  input  logic clk,
  input  logic tick,
  input  logic mstr_rst,
  input  logic pwr_rst_req,
  input  logic auto_rst_off,
  input  logic sel_a,
  input  logic sel_b,
  input  logic recycle,
  input  logic pol_hi,
  output logic tmr_out
);

  // Named internal events, also observed by the bound checker
  logic             rst_act;
  logic             mode_chg;
  logic             shot;
  logic             tap;
  logic             cnt_clr;
  logic             cnt_adv;
  logic [CNT_W-1:0] cnt;
  tap_sel_e         sel;
  logic             out_q;
  logic             active_lvl;

  assign rst_act = mstr_rst || (pwr_rst_req && !auto_rst_off);
  assign cnt_clr = rst_act || mode_chg;
  assign cnt_adv = tick && !cnt_clr;
  assign sel     = pack_sel(sel_a, sel_b);

  bt_stage_counter #(
    .W(CNT_W)
  ) u_cnt (
    .clk (clk),
    .clr (cnt_clr),
    .adv (cnt_adv),
    .cnt (cnt)
  );

  bt_tap_mux #(
    .W  (CNT_W),
    .S00(STG_00),
    .S01(STG_01),
    .S10(STG_10),
    .S11(STG_11)
  ) u_mux (
    .cnt (cnt),
    .sel (sel),
    .tap (tap)
  );

  bt_shot_ctl u_shot (
    .clk      (clk),
    .rst_act  (rst_act),
    .recycle  (recycle),
    .tap      (tap),
    .mode_chg (mode_chg),
    .shot     (shot)
  );

  // Recycle follows the tap; single-cycle keeps the flip once the latch holds it
  assign active_lvl = recycle ? tap : (tap || shot);

  always_ff @(posedge clk) begin
    if (cnt_clr)
      out_q <= pol_hi;
    else
      out_q <= pol_hi ^ active_lvl;
  end

  assign tmr_out = out_q;

endmodule

// File: rtl/bt_timer_chk.sv
module bt_timer_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_act,
  input logic         tick,
  input logic         recycle,
  input logic         pol_hi,
  input logic         mode_chg,
  input logic         shot,
  input logic         tap,
  input logic [W-1:0] cnt,
  input logic         tmr_out
);

  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  // R3 and R5: reset clears the count and shows the polarity level
  a_r3_reset_clears: assert property (@(posedge clk)
    rst_act |=> (cnt == '0) && (tmr_out == $past(pol_hi)));

  // R2: no tick, no movement
  a_r2_idle_holds: assert property (@(posedge clk) disable iff (rst_act)
    (!tick && !mode_chg) |=> $stable(cnt));

  // R2: a tick advances by exactly one
  a_r2_tick_steps: assert property (@(posedge clk) disable iff (rst_act)
    (tick && !mode_chg) |=> cnt == ($past(cnt) + ONE));

  // R8: mode change restarts the timer and disarms the latch
  a_r8_mode_restart: assert property (@(posedge clk) disable iff (rst_act)
    mode_chg |=> (cnt == '0) && !shot && (tmr_out == $past(pol_hi)));

  // R6: recycle output tracks the tapped stage one clock later
  a_r6_recycle_follow: assert property (@(posedge clk) disable iff (rst_act)
    (recycle && !mode_chg) |=> tmr_out == ($past(tap) ^ $past(pol_hi)));

  // R7: a set latch keeps the output at the inverted level
  a_r7_shot_holds: assert property (@(posedge clk) disable iff (rst_act)
    (!recycle && shot && !mode_chg) |=> tmr_out == !$past(pol_hi));

endmodule

bind binary_timer bt_timer_chk #(
  .W(CNT_W)
) u_chk (
  .clk      (clk),
  .rst_act  (rst_act),
  .tick     (tick),
  .recycle  (recycle),
  .pol_hi   (pol_hi),
  .mode_chg (mode_chg),
  .shot     (shot),
  .tap      (tap),
  .cnt      (cnt),
  .tmr_out  (tmr_out)
);

// File: tb/test_binary_timer.sv
module test_binary_timer;

  localparam int CLK_P = 10;
  localparam int WDOG  = 150000;

  logic clk = 1'b0;
  logic tick = 1'b0;
  logic mstr_rst = 1'b1;
  logic pwr_rst_req = 1'b1;
  logic auto_rst_off = 1'b0;
  logic sel_a = 1'b1;
  logic sel_b = 1'b0;
  logic recycle = 1'b1;
  logic pol_hi = 1'b0;
  logic tmr_out;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  binary_timer i_binary_timer (
    .clk          (clk),
    .tick         (tick),
    .mstr_rst     (mstr_rst),
    .pwr_rst_req  (pwr_rst_req),
    .auto_rst_off (auto_rst_off),
    .sel_a        (sel_a),
    .sel_b        (sel_b),
    .recycle      (recycle),
    .pol_hi       (pol_hi),
    .tmr_out      (tmr_out)
  );

  // Ticks until the first flip, restated from the requirement table
  function automatic int first_flip(input logic a, input logic b);
    case ({a, b})
      2'b00:   return 4096;
      2'b01:   return 512;
      2'b10:   return 128;
      default: return 32768;
    endcase
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: tmr_out=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Called at a negedge; holds tick for n edges, then lets the output settle
  task automatic run(input int n);
    if (n > 0) begin
      tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic apply_mr(input string req);
    @(negedge clk);
    mstr_rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(req, tmr_out, pol_hi);
    mstr_rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_select(input logic a, input logic b);
    int h;
    h = first_flip(a, b);
    sel_a = a; sel_b = b; recycle = 1'b1; pol_hi = 1'b0;
    apply_mr("R3");
    run(h - 1);
    chk("R1 before flip", tmr_out, 1'b0);
    run(1);
    chk("R1 at flip", tmr_out, 1'b1);
  endtask

  task automatic t_recycle();
    sel_a = 1'b1; sel_b = 1'b0; recycle = 1'b1; pol_hi = 1'b0;
    apply_mr("R3");
    run(127); chk("R6 first half", tmr_out, 1'b0);
    run(1);   chk("R6 rise", tmr_out, 1'b1);
    run(127); chk("R6 high half", tmr_out, 1'b1);
    run(1);   chk("R6 fall", tmr_out, 1'b0);
    run(128); chk("R6 second rise", tmr_out, 1'b1);
  endtask

  task automatic t_single();
    sel_a = 1'b1; sel_b = 1'b0; pol_hi = 1'b0;
    @(negedge clk); recycle = 1'b0;
    apply_mr("R3");
    run(127); chk("R7 before flip", tmr_out, 1'b0);
    run(1);   chk("R7 flip", tmr_out, 1'b1);
    run(300); chk("R7 held after wrap", tmr_out, 1'b1);
    run(128); chk("R7 still held", tmr_out, 1'b1);
  endtask

  task automatic t_rearm();
    // latch is set from t_single; a mode change re-arms it
    @(negedge clk); recycle = 1'b1;
    repeat (2) @(negedge clk);
    chk("R8 back to reset level", tmr_out, 1'b0);
    run(127); chk("R8 restart from zero", tmr_out, 1'b0);
    run(1);   chk("R8 flip after restart", tmr_out, 1'b1);
    @(negedge clk); recycle = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8 single re-armed", tmr_out, 1'b0);
    run(127); chk("R8 single before flip", tmr_out, 1'b0);
    run(1);   chk("R8 single flip", tmr_out, 1'b1);
  endtask

  task automatic t_polarity();
    sel_a = 1'b1; sel_b = 1'b0; pol_hi = 1'b1;
    @(negedge clk); recycle = 1'b1;
    apply_mr("R5 reset level high");
    run(127); chk("R5 holds high", tmr_out, 1'b1);
    run(1);   chk("R5 flips low", tmr_out, 1'b0);
    pol_hi = 1'b0;
  endtask

  task automatic t_idle();
    sel_a = 1'b1; sel_b = 1'b0; recycle = 1'b1; pol_hi = 1'b0;
    apply_mr("R3");
    run(127);
    repeat (300) @(negedge clk);
    chk("R2 no tick no change", tmr_out, 1'b0);
    mstr_rst = 1'b1; tick = 1'b1;
    repeat (10) @(negedge clk);
    chk("R3 reset while ticking", tmr_out, 1'b0);
    mstr_rst = 1'b0; tick = 1'b0;
    @(negedge clk);
    run(1);   chk("R3 count was cleared", tmr_out, 1'b0);
    run(126); chk("R3 still below flip", tmr_out, 1'b0);
    run(1);   chk("R3 flip from zero", tmr_out, 1'b1);
  endtask

  task automatic t_por();
    sel_a = 1'b1; sel_b = 1'b0; recycle = 1'b1; pol_hi = 1'b0;
    apply_mr("R3");
    run(130); chk("R4 setup", tmr_out, 1'b1);
    auto_rst_off = 1'b1; pwr_rst_req = 1'b1;
    repeat (3) @(negedge clk);
    chk("R4 request masked", tmr_out, 1'b1);
    pwr_rst_req = 1'b0;
    @(negedge clk);
    run(126); chk("R4 count kept", tmr_out, 1'b0);
    auto_rst_off = 1'b0; pwr_rst_req = 1'b1;
    run(10);
    chk("R4 request resets", tmr_out, 1'b0);
    pwr_rst_req = 1'b0;
    @(negedge clk);
    run(127); chk("R4 from zero", tmr_out, 1'b0);
    run(1);   chk("R4 flip", tmr_out, 1'b1);
  endtask

  task automatic t_sel_change();
    sel_a = 1'b1; sel_b = 1'b0; recycle = 1'b1; pol_hi = 1'b0;
    apply_mr("R3");
    run(100);
    sel_a = 1'b0; sel_b = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 new tap low", tmr_out, 1'b0);
    run(411); chk("R9 count kept", tmr_out, 1'b0);
    run(1);   chk("R9 flip on new tap", tmr_out, 1'b1);
    sel_a = 1'b1; sel_b = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 short tap bit low", tmr_out, 1'b0);
  endtask

  task automatic t_latency();
    sel_a = 1'b1; sel_b = 1'b0; recycle = 1'b1; pol_hi = 1'b0;
    apply_mr("R3");
    run(127);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    chk("R10 not yet", tmr_out, 1'b0);
    @(negedge clk);
    chk("R10 one clock later", tmr_out, 1'b1);
  endtask

  initial begin : wdog
    repeat (WDOG) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    chk("R3 reset state", tmr_out, 1'b0);
    pwr_rst_req = 1'b0;
    mstr_rst = 1'b0;
    @(negedge clk);
    t_latency();
    t_select(1'b0, 1'b0);
    t_select(1'b0, 1'b1);
    t_select(1'b1, 1'b0);
    t_select(1'b1, 1'b1);
    t_recycle();
    t_single();
    t_rearm();
    t_polarity();
    t_idle();
    t_por();
    t_sel_change();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule